// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is a synthesizable stand-in for a small serial EEPROM on a four-wire serial bus. A bus master lowers the chip select, clocks in an 8-bit instruction and, depending on the instruction, a two-byte address and data bytes. The slave then answers on its serial output. The block keeps a write-enable flag, a protection configuration and a byte array whose size is a parameter. It services reads, page-bounded writes and status queries.

The serial lines are oversampled by the block's own system clock. A completed write or status update starts an internal write interval that a counter stands in for. While the interval runs, the slave answers status queries and drops every other instruction. The protection settings can block writes to the top quarter, the top half or all of the array. A protect-enable bit, taken together with the write-protect input pin, can block writes altogether.

Top module: `spi_eeprom_slave`

## Requirements
- R1: An instruction byte is decoded only when its bits 7:4 are zero, and bit 3 is ignored. Bits 2:0 select the command: 110 set write enable, 100 clear write enable, 101 read status, 001 write status, 011 read array, 010 write array. Every other byte is ignored for the rest of the transaction.
- R2: Every byte moves most significant bit first in bus mode 0. MOSI is sampled on rising SCK. MISO changes after falling SCK and is 0 while CS_n is high.
- R3: The write-enable flag is 0 after reset, and the status then reads 0x00. An array write or status write sent while the flag is 0 changes nothing.
- R4: The clear-write-enable command clears the flag whatever the level of wp_n.
- R5: The status byte is {protect-enable, 3'b000, bp[1:0], write-enable, busy}. Bits 6:4 read 0 whenever no write interval is running.
- R6: A write interval lasts WRITE_CYCLES clocks. During it the status reads 0xFF. When it ends the write-enable flag is 0.
- R7: A status write takes protect-enable from data bit 7 and bp[1:0] from data bits 3:2.
- R8: A read takes a two-byte address. The address is used modulo MEM_BYTES, and the upper bits are ignored. The read returns consecutive bytes for as long as CS_n stays low, wrapping from the last byte to byte 0.
- R9: A write (array or status) starts only if CS_n rises after a whole number of bytes and at least one data byte has arrived. Otherwise nothing changes and the write-enable flag is kept.
- R10: While a write interval runs, only the read-status command is obeyed. Any other instruction is dropped, and a dropped read returns 0x00 bytes.
- R11: Array write data fills successive addresses and wraps within the aligned PAGE_BYTES page that holds the start address.
- R12: An array write is blocked when protect-enable is 1 and wp_n is 0. It is also blocked when its page lies in the protected region: none for bp=0, addresses >= 3/4 of the array for bp=1, >= 1/2 for bp=2, and the whole array for bp=3. A blocked write starts no interval and keeps the write-enable flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| wp_n | input | 1 | Active-low write-protect pin |
| miso | output | 1 | Serial data to the master |

## Verification
The array is filled page by page with an address-derived pattern and then read back in one sweep that starts near the top, which covers MSB-first shifting, sequential addressing and the wrap to byte 0. All four protection settings are tried against a write into each quarter of the array. Protect-enable is tried with both pin levels, which separates the region check from the pin check. A write started near a page end shows the in-page wrap. Writes cut off mid-byte or without data, and commands sent during the write interval, each show that a rejected transaction leaves both the array and the flag unchanged. Instruction bytes with bit 3 set and with a nonzero top nibble separate the don't-care bit from bits that must be zero.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
  } op_e;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR_HI, ST_ADDR_LO, ST_RDATA, ST_WDATA, ST_WSR, ST_STAT, ST_IGNORE
  } st_e;

  // instruction decode; bit 3 of the byte is not passed in (don't care)
  function automatic op_e decode_op(input logic [3:0] hi, input logic [2:0] lo);
    if (hi != 4'd0) return OP_NONE;
    case (lo)
      3'b110:  return OP_WREN;
      3'b100:  return OP_WRDI;
      3'b101:  return OP_RDSR;
      3'b001:  return OP_WRSR;
      3'b011:  return OP_READ;
      3'b010:  return OP_WRITE;
      default: return OP_NONE;
    endcase
  endfunction

  // array write protection by pin and by region
  function automatic logic wr_blocked(input int unsigned mem_bytes, input int unsigned addr,
                                      input logic [1:0] bp, input logic wpen, input logic wp_n);
    if (wpen && !wp_n) return 1'b1;
    case (bp)
      2'd0:    return 1'b0;
      2'd1:    return addr >= (mem_bytes - mem_bytes / 4);
      2'd2:    return addr >= (mem_bytes / 2);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_word(input logic busy, input logic wpen,
                                             input logic [1:0] bp, input logic wel);
    if (busy) return 8'hFF;
    return {wpen, 3'b000, bp, wel, 1'b0};
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       on_boundary,
  output logic       cs_rise,
  output logic       cs_fall,
  output logic       miso
);
  logic       sck_q, cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       sck_rise, sck_fall;

  assign sck_rise    = sck & ~sck_q & ~cs_n;
  assign sck_fall    = ~sck & sck_q & ~cs_n;
  assign cs_fall     = ~cs_n & cs_q;
  assign cs_rise     = cs_n & ~cs_q;
  assign byte_done   = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte     = {rx_sh, mosi};
  assign on_boundary = (bit_cnt == 3'd0);
  assign miso        = ~cs_n & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_fall) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          rx_sh   <= {rx_sh[5:0], mosi};
        end
        if (sck_fall)
          tx_sh <= on_boundary ? tx_byte : {tx_sh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/write_cycle_timer.sv
module write_cycle_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= CNT_W'(CYCLES);
    else if (busy)  cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int PAGE_W  = $clog2(PAGE_BYTES);
  localparam int PBASE_W = ADDR_W - PAGE_W;

  logic             byte_done, on_boundary, cs_rise, cs_fall;
  logic [7:0]       rx_byte, tx_byte, status;
  logic             busy, cycle_start, cycle_end;
  logic             wr_ok, sr_ok;
  op_e              op;
  st_e              state;
  logic             is_read, wel, wpen, wsr_wpen, wsr_got;
  logic [1:0]       bp, wsr_bp;
  logic [7:0]       addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic [PBASE_W-1:0] pbase;
  logic [PAGE_W-1:0]  poff;
  logic [7:0]       pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [7:0]       mem  [MEM_BYTES];

  spi_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .on_boundary(on_boundary), .cs_rise(cs_rise), .cs_fall(cs_fall), .miso(miso)
  );

  write_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cycle_start), .busy(busy), .done(cycle_end)
  );

  assign op     = decode_op(rx_byte[7:4], rx_byte[2:0]);
  assign status = status_word(busy, wpen, bp, wel);

  always_comb begin
    case (state)
      ST_STAT:  tx_byte = status;
      ST_RDATA: tx_byte = mem[ptr];
      default:  tx_byte = 8'h00;
    endcase
  end

  assign wr_ok = (state == ST_WDATA) && (|pmask) &&
                 !wr_blocked(MEM_BYTES, 32'({pbase, {PAGE_W{1'b0}}}), bp, wpen, wp_n);
  assign sr_ok = (state == ST_WSR) && wsr_got;
  assign cycle_start = cs_rise && on_boundary && !busy && wel && (wr_ok || sr_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IGNORE;
      is_read  <= 1'b0;
      wel      <= 1'b0;
      wpen     <= 1'b0;
      bp       <= '0;
      wsr_wpen <= 1'b0;
      wsr_bp   <= '0;
      wsr_got  <= 1'b0;
      addr_hi  <= '0;
      ptr      <= '0;
      pbase    <= '0;
      poff     <= '0;
      pmask    <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
      for (int i = 0; i < MEM_BYTES; i++)  mem[i]  <= '0;
    end else begin
      if (cycle_start) begin
        if (state == ST_WSR) begin
          wpen <= wsr_wpen;
          bp   <= wsr_bp;
        end else begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (pmask[i]) mem[{pbase, PAGE_W'(i)}] <= pbuf[i];
        end
      end
      if (cycle_end) wel <= 1'b0;
      if (cs_fall) begin
        state   <= ST_CMD;
        pmask   <= '0;
        wsr_got <= 1'b0;
      end else if (byte_done) begin
        case (state)
          ST_CMD: begin
            if (busy && op != OP_RDSR) state <= ST_IGNORE;
            else begin
              case (op)
                OP_WREN:  begin wel <= 1'b1; state <= ST_IGNORE; end
                OP_WRDI:  begin wel <= 1'b0; state <= ST_IGNORE; end
                OP_RDSR:  state <= ST_STAT;
                OP_WRSR:  state <= ST_WSR;
                OP_READ:  begin is_read <= 1'b1; state <= ST_ADDR_HI; end
                OP_WRITE: begin is_read <= 1'b0; state <= ST_ADDR_HI; end
                default:  state <= ST_IGNORE;
              endcase
            end
          end
          ST_ADDR_HI: begin
            addr_hi <= rx_byte;
            state   <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            if (is_read) begin
              ptr   <= ADDR_W'({addr_hi, rx_byte});
              state <= ST_RDATA;
            end else begin
              pbase <= PBASE_W'({addr_hi, rx_byte} >> PAGE_W);
              poff  <= PAGE_W'({addr_hi, rx_byte});
              state <= ST_WDATA;
            end
          end
          ST_RDATA: ptr <= ptr + ADDR_W'(1);
          ST_WDATA: begin
            pbuf[poff]  <= rx_byte;
            pmask[poff] <= 1'b1;
            poff        <= poff + PAGE_W'(1);
          end
          ST_WSR: begin
            wsr_wpen <= rx_byte[7];
            wsr_bp   <= rx_byte[3:2];
            wsr_got  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic wel,
  input logic busy,
  input logic cycle_start,
  input logic cycle_end,
  input logic cs_rise,
  input logic on_boundary
);
  assert_start_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> wel);

  assert_start_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (cs_rise && on_boundary));

  assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> busy);

  assert_wel_drops_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !wel);

  assert_wel_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycle_end) |=> (wel == $past(wel)));
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wel(wel), .busy(busy), .cycle_start(cycle_start),
  .cycle_end(cycle_end), .cs_rise(cs_rise), .on_boundary(on_boundary)
);

// File: tb/spi_eeprom_slave_tb.sv
`timescale 1ns/1ps
module spi_eeprom_slave_tb;
  localparam int MEM = 256;
  localparam int PG  = 32;
  localparam int WC  = 200;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;
  int   n_cmp = 0, n_bad = 0;

  logic [7:0] exp_mem [MEM];
  logic       wel_m = 1'b0, wpen_m = 1'b0;
  logic [1:0] bp_m = 2'd0;
  logic       pend_cycle = 1'b0;

  always #10 clk = ~clk;

  spi_eeprom_slave #(.MEM_BYTES(MEM), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n), .miso(miso)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic spi_begin();
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx);
    logic [7:0] d;
    xbits(tx, 8, d);
  endtask

  task automatic cmd1(input logic [7:0] op);
    spi_begin(); xb(op); spi_end();
  endtask

  task automatic rdsr(output logic [7:0] s);
    spi_begin(); xb(8'h05); xbits(8'h00, 8, s); spi_end();
  endtask

  function automatic logic [7:0] stat_m();
    return {wpen_m, 3'b000, bp_m, wel_m, 1'b0};
  endfunction

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 7) ^ (seed * 29) ^ 8'h5A);
  endfunction

  // protected-region limit restated as a lookup of the first blocked address
  function automatic logic blocked_m(input int a);
    int lim;
    lim = (bp_m == 2'd0) ? MEM : (bp_m == 2'd1) ? (MEM * 3) / 4 : (bp_m == 2'd2) ? MEM / 2 : 0;
    return (wpen_m && !wp_n) || (a >= lim);
  endfunction

  // sets WEL, writes n bytes at addr, updates model; no waiting
  task automatic start_write(input logic [7:0] op, input int a, input int n, input int seed);
    int base;
    cmd1(8'h06); wel_m = 1'b1;
    spi_begin(); xb(op); xb(8'h00); xb(8'(a));
    for (int k = 0; k < n; k++) xb(pat(a + k, seed));
    spi_end();
    base = a - (a % PG);
    pend_cycle = !blocked_m(base);
    if (pend_cycle)
      for (int k = 0; k < n; k++) exp_mem[base + ((a % PG) + k) % PG] = pat(a + k, seed);
  endtask

  task automatic finish_write(input string tag);
    logic [7:0] s;
    if (pend_cycle) begin
      rdsr(s); chk({tag, " R6 busy status"}, s, 8'hFF);
      repeat (WC + 30) @(negedge clk);
      wel_m = 1'b0;
    end
    rdsr(s); chk({tag, " status after"}, s, stat_m());
    pend_cycle = 1'b0;
  endtask

  task automatic wrsr(input logic [7:0] d);
    cmd1(8'h06); wel_m = 1'b1;
    spi_begin(); xb(8'h01); xb(d); spi_end();
    wpen_m = d[7]; bp_m = d[3:2]; pend_cycle = 1'b1;
    finish_write("R7 wrsr");
  endtask

  task automatic read_chk(input logic [7:0] op, input int a, input int n, input string tag);
    logic [7:0] d;
    spi_begin(); xb(op); xb(8'h3C); xb(8'(a));
    for (int k = 0; k < n; k++) begin
      xbits(8'h00, 8, d);
      chk(tag, d, exp_mem[(a + k) % MEM]);
    end
    spi_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    for (int i = 0; i < MEM; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R2 miso idle", {7'd0, miso}, 8'h00);
    rdsr(s); chk("R3 R5 reset status", s, 8'h00);

    // write without enable
    spi_begin(); xb(8'h02); xb(8'h00); xb(8'h10); xb(8'hAA); spi_end();
    repeat (WC + 30) @(negedge clk);
    rdsr(s); chk("R3 no-enable status", s, 8'h00);
    read_chk(8'h03, 8'h10, 1, "R3 no-enable data");

    // decode with bit 3 don't care; WRDI independent of pin
    cmd1(8'h06); rdsr(s); chk("R1 wren 06", s, 8'h02);
    wp_n = 1'b0; cmd1(8'h0C); rdsr(s); chk("R4 wrdi 0C wp low", s, 8'h00);
    wp_n = 1'b1; cmd1(8'h0E); rdsr(s); chk("R1 wren 0E", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R4 wrdi 04 wp high", s, 8'h00);
    cmd1(8'h16); rdsr(s); chk("R1 nonzero top nibble ignored", s, 8'h00);
    spi_begin(); xb(8'h0D); xbits(8'h00, 8, s); xbits(8'h00, 8, d); spi_end();
    chk("R1 rdsr 0D", s, 8'h00); chk("R5 repeated status", d, 8'h00);
    chk("R2 miso idle after", {7'd0, miso}, 8'h00);

    // fill whole array page by page
    for (int p = 0; p < MEM / PG; p++) begin
      start_write((p % 2) ? 8'h0A : 8'h02, p * PG, PG, 1);
      finish_write("R6 fill");
    end

    // sequential read with wrap
    read_chk(8'h0B, MEM - 16, MEM + 32, "R8 sweep");

    // in-page wrap
    start_write(8'h02, 8'h5E, 5, 2); finish_write("R11 wrap");
    read_chk(8'h03, 8'h40, PG, "R11 page");

    // incomplete writes
    cmd1(8'h06); wel_m = 1'b1;
    spi_begin(); xb(8'h02); xb(8'h00); xb(8'h20); xb(8'hE7); xbits(8'h81, 3, d); spi_end();
    rdsr(s); chk("R9 partial byte status", s, 8'h02);
    spi_begin(); xb(8'h02); xb(8'h00); xb(8'h21); spi_end();
    rdsr(s); chk("R9 no data status", s, 8'h02);
    read_chk(8'h03, 8'h20, 2, "R9 data kept");
    cmd1(8'h04); wel_m = 1'b0;

    // commands during write interval
    start_write(8'h02, 8'h30, 1, 3);
    spi_begin(); xb(8'h03); xb(8'h00); xb(8'h30); xbits(8'h00, 8, d); spi_end();
    chk("R10 read dropped", d, 8'h00);
    repeat (WC + 30) @(negedge clk); wel_m = 1'b0; pend_cycle = 1'b0;
    start_write(8'h02, 8'h31, 1, 4);
    spi_begin(); xb(8'h02); xb(8'h00); xb(8'h32); xb(8'h77); spi_end();
    repeat (WC + 30) @(negedge clk); wel_m = 1'b0; pend_cycle = 1'b0;
    rdsr(s); chk("R10 status after", s, 8'h00);
    read_chk(8'h03, 8'h30, 3, "R10 array");

    // block protect sweep
    for (int b = 0; b < 4; b++) begin
      wrsr(8'h70 | 8'(b << 2) | 8'h03);
      for (int q = 0; q < 4; q++) begin
        start_write(8'h02, q * (MEM / 4) + 8, 2, 10 + b * 4 + q);
        finish_write("R12 region");
        read_chk(8'h03, q * (MEM / 4) + 8, 2, "R12 region data");
        if (wel_m) begin cmd1(8'h04); wel_m = 1'b0; end
      end
    end

    // pin protection
    wrsr(8'h80);
    wp_n = 1'b0;
    start_write(8'h02, 8'h08, 2, 50); finish_write("R12 pin low");
    read_chk(8'h03, 8'h08, 2, "R12 pin low data");
    cmd1(8'h04); wel_m = 1'b0;
    wp_n = 1'b1;
    start_write(8'h02, 8'h08, 2, 51); finish_write("R12 pin high");
    read_chk(8'h03, 8'h08, 2, "R12 pin high data");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule